// File: doc/BRIEF.md
# Presettable Decade Counter Stage

This block is a single synchronous digit counter that steps through 0 to 9 and then wraps to 0. The count advances on the rising clock edge. An active-low asynchronous clear drives the digit to zero at once. An active-low synchronous load copies a 4-bit preset value into the digit on the next edge, and this load takes priority over counting.

Counting needs two active-high enables, and they do different jobs. `cnt_en` only gates counting. `chain_en` gates counting and also qualifies the carry output. The carry output is combinational, so several stages on one clock can be chained into a multi-digit synchronous counter: each stage's `carry_out` feeds the `chain_en` of the next stage up. A digit above 9 can be loaded, and from any such code the stage falls back into the 0 to 9 sequence within two counting edges.

The modulus and the next-state variant are parameters. With the default modulus of ten, a toggle-mask form is used. Any other modulus uses a compare-and-wrap form.

Top module: `dec_counter_stage`

## Requirements
- R1: While `arst_n` is low, `digit` reads 0000 with no clock edge needed, and it stays 0000 across clock edges.
- R2: With `arst_n` high and `ld_n` low, `digit` takes `preset_d` on the next rising edge. `preset_d[0]` is the least significant bit. The load happens whatever the values of both enables.
- R3: With `arst_n` and `ld_n` high, `digit` advances on a rising edge only when `cnt_en` and `chain_en` are both 1. Otherwise it holds its value.
- R4: In counting, the digit steps through 0,1,...,8,9 and then back to 0.
- R5: `carry_out` is 1 exactly when `chain_en` is 1 and `digit` is 1001. It does not depend on `cnt_en` or `ld_n`.
- R6: Each code above 9 reaches the decimal sequence within two counting edges:
  - 1010 goes to 1011, then to 0110.
  - 1100 goes to 1101, then to 0100.
  - 1110 goes to 1111, then to 0010.
- R7: Two stages on a shared clock, with the low stage's `carry_out` on the high stage's `chain_en`, count 00 to 99 and then wrap to 00.
- R8: A low `arst_n` overrides a simultaneous low `ld_n` and both enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| arst_n | input | 1 | Asynchronous clear, active low |
| ld_n | input | 1 | Synchronous preset load, active low |
| cnt_en | input | 1 | Count enable, gates counting only |
| chain_en | input | 1 | Count enable that also qualifies the carry |
| preset_d | input | 4 | Value loaded when `ld_n` is low |
| digit | output | 4 | Current count, binary-coded decimal |
| carry_out | output | 1 | Terminal-count flag used for cascading |

## Verification
The bench drives several kinds of stimulus, and each one separates a different part of the block:
- A directed run (clear, load 7, count to 3, then hold) shows whether the sequence and the carry pulse are right.
- Holding each enable low on its own, with the digit at 9, separates the hold path from the carry gating.
- All six codes above 9 are loaded and stepped, which exposes any fault in the toggle-mask equations that valid states never reach.
- Clear asserted between edges, and clear held together with load, test the asynchronous priority.
- A long random run mixes load, clear and enable patterns against a behavioural model.
- A two-stage chain counted through 99 shows whether the carry reaches the upper digit in the same cycle.

// File: rtl/dec_ctr_pkg.sv
package dec_ctr_pkg;
   localparam int unsigned BCD_W = 4;
   typedef logic [BCD_W-1:0] bcd_t;

   // Toggle mask for a decade digit: a set bit flips on a counting edge.
   function automatic bcd_t bcd_toggle_mask(input bcd_t s);
      bcd_t t;
      t[0] = 1'b1;
      t[1] = s[0] & ~s[3];
      t[2] = s[0] & s[1];
      t[3] = (s[0] & s[1] & s[2]) | (s[0] & s[3]);
      return t;
   endfunction
endpackage

// File: rtl/dec_next_state.sv
module dec_next_state #(
   parameter int unsigned WIDTH      = 4,
   parameter int unsigned MODULUS    = 10,
   parameter bit          USE_TOGGLE = 1'b1
) (
   input  logic [WIDTH-1:0] cur,
   output logic [WIDTH-1:0] nxt
);
   import dec_ctr_pkg::*;

   localparam logic [WIDTH-1:0] TERM = WIDTH'(MODULUS - 1);

   generate
      if (USE_TOGGLE) begin : g_toggle
         if (MODULUS != 10 || WIDTH != BCD_W) begin : g_bad
            $error("toggle-mask variant needs a 4-bit decade digit");
         end
         always_comb nxt = cur ^ bcd_toggle_mask(cur);
      end else begin : g_compare
         always_comb begin
            if (cur >= TERM) nxt = '0;
            else             nxt = cur + WIDTH'(1);
         end
      end
   endgenerate
endmodule

// File: rtl/dec_state_reg.sv
module dec_state_reg #(
   parameter int unsigned WIDTH = 4
) (
   input  logic             clk,
   input  logic             arst_n,
   input  logic             ld_n,
   input  logic             step,
   input  logic [WIDTH-1:0] load_val,
   input  logic [WIDTH-1:0] step_val,
   output logic [WIDTH-1:0] state
);
   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n)     state <= '0;
      else if (!ld_n)  state <= load_val;
      else if (step)   state <= step_val;
   end
endmodule

// File: rtl/dec_carry.sv
module dec_carry #(
   parameter int unsigned WIDTH   = 4,
   parameter int unsigned MODULUS = 10
) (
   input  logic [WIDTH-1:0] state,
   input  logic             qual,
   output logic             carry
);
   localparam logic [WIDTH-1:0] TERM = WIDTH'(MODULUS - 1);

   always_comb carry = qual & (state == TERM);
endmodule

// File: rtl/dec_counter_stage.sv
module dec_counter_stage #(
   parameter int unsigned MODULUS    = 10,
   parameter bit          USE_TOGGLE = 1'b1,
   localparam int unsigned WIDTH     = (MODULUS > 1) ? $clog2(MODULUS) : 1
) (
   input  logic             clk,
   input  logic             arst_n,
   input  logic             ld_n,
   input  logic             cnt_en,
   input  logic             chain_en,
   input  logic [WIDTH-1:0] preset_d,
   output logic [WIDTH-1:0] digit,
   output logic             carry_out
);
   generate
      if (MODULUS < 2) begin : g_bad_mod
         $error("MODULUS must be at least 2");
      end
   endgenerate

   logic             step;
   logic [WIDTH-1:0] step_val;

   assign step = cnt_en & chain_en;

   dec_next_state #(
      .WIDTH(WIDTH), .MODULUS(MODULUS), .USE_TOGGLE(USE_TOGGLE)
   ) u_next (
      .cur(digit),
      .nxt(step_val)
   );

   dec_state_reg #(.WIDTH(WIDTH)) u_reg (
      .clk(clk),
      .arst_n(arst_n),
      .ld_n(ld_n),
      .step(step),
      .load_val(preset_d),
      .step_val(step_val),
      .state(digit)
   );

   dec_carry #(.WIDTH(WIDTH), .MODULUS(MODULUS)) u_carry (
      .state(digit),
      .qual(chain_en),
      .carry(carry_out)
   );
endmodule

// File: rtl/dec_counter_chk.sv
module dec_counter_chk #(
   parameter int unsigned WIDTH   = 4,
   parameter int unsigned MODULUS = 10
) (
   input logic             clk,
   input logic             arst_n,
   input logic             ld_n,
   input logic             cnt_en,
   input logic             chain_en,
   input logic [WIDTH-1:0] preset_d,
   input logic [WIDTH-1:0] digit,
   input logic             carry_out
);
   localparam logic [WIDTH-1:0] TERM = WIDTH'(MODULUS - 1);

   always_ff @(posedge clk) begin
      if (!arst_n) begin
         a_r1_clear_zero: assert (digit == '0);
      end
   end

   a_r2_load_takes_preset: assert property (@(posedge clk) disable iff (!arst_n)
      !ld_n |=> digit == $past(preset_d));

   a_r3_hold_when_gated: assert property (@(posedge clk) disable iff (!arst_n)
      (ld_n && !(cnt_en && chain_en)) |=> $stable(digit));

   a_r4_increment: assert property (@(posedge clk) disable iff (!arst_n)
      (ld_n && cnt_en && chain_en && digit < TERM) |=> digit == $past(digit) + WIDTH'(1));

   a_r4_wrap: assert property (@(posedge clk) disable iff (!arst_n)
      (ld_n && cnt_en && chain_en && digit == TERM) |=> digit == '0);

   a_r5_carry_terminal: assert property (@(posedge clk) disable iff (!arst_n)
      carry_out |-> (chain_en && digit == TERM));

   a_r5_carry_present: assert property (@(posedge clk) disable iff (!arst_n)
      (chain_en && digit == TERM) |-> carry_out);
endmodule

bind dec_counter_stage dec_counter_chk #(.WIDTH(WIDTH), .MODULUS(MODULUS)) u_chk (
   .clk(clk), .arst_n(arst_n), .ld_n(ld_n), .cnt_en(cnt_en),
   .chain_en(chain_en), .preset_d(preset_d), .digit(digit), .carry_out(carry_out)
);

// File: tb/sim_dec_counter_stage.sv
module sim_dec_counter_stage;
   localparam time TCK = 8ns;

   logic clk = 1'b0;
   logic arst_n = 1'b0, ld_n = 1'b1, cnt_en = 1'b0, chain_en = 1'b0;
   logic [3:0] preset_d = '0;
   logic [3:0] digit;
   logic carry_out;

   logic cas_rst_n = 1'b0, cas_run = 1'b0;
   logic [3:0] lo_d, hi_d;
   logic lo_c, hi_c;

   int n_chk = 0, n_bad = 0;
   int model = 0;

   always #(TCK/2) clk = ~clk;

   dec_counter_stage u0 (
      .clk(clk), .arst_n(arst_n), .ld_n(ld_n), .cnt_en(cnt_en), .chain_en(chain_en),
      .preset_d(preset_d), .digit(digit), .carry_out(carry_out)
   );

   dec_counter_stage c_lo (
      .clk(clk), .arst_n(cas_rst_n), .ld_n(1'b1), .cnt_en(cas_run), .chain_en(1'b1),
      .preset_d(4'd0), .digit(lo_d), .carry_out(lo_c)
   );

   dec_counter_stage c_hi (
      .clk(clk), .arst_n(cas_rst_n), .ld_n(1'b1), .cnt_en(cas_run), .chain_en(lo_c),
      .preset_d(4'd0), .digit(hi_d), .carry_out(hi_c)
   );

   task automatic check(input string tag, input int got, input int exp);
      n_chk++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
      end
   endtask

   function automatic int ref_step(input int s);
      case (s)
         9:  return 0;
         10: return 11;
         11: return 6;
         12: return 13;
         13: return 4;
         14: return 15;
         15: return 2;
         default: return s + 1;
      endcase
   endfunction

   // Drive at negedge, model the edge, compare at the following negedge.
   task automatic tick(input logic r, input logic l, input logic ep, input logic et,
                       input logic [3:0] d, input string tag);
      arst_n = r; ld_n = l; cnt_en = ep; chain_en = et; preset_d = d;
      @(posedge clk);
      if (!r)           model = 0;
      else if (!l)      model = d;
      else if (ep && et) model = ref_step(model);
      @(negedge clk);
      check({tag, " digit"}, digit, model);
      check({tag, " carry R5"}, carry_out, (et && model == 9) ? 1 : 0);
   endtask

   initial begin
      #(TCK * 200000);
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      @(negedge clk);
      check("R1 clear at start", digit, 0);
      // Directed reference run: load 7, count to 3, inhibit (R2, R4, R5)
      tick(1, 0, 0, 0, 4'd7, "R2 load over disabled enables");
      for (int i = 0; i < 6; i++) tick(1, 1, 1, 1, 4'd0, "R4 sequence");
      check("R4 reached three", digit, 3);
      tick(1, 1, 0, 1, 4'd0, "R3 hold cnt_en low");
      tick(1, 1, 1, 0, 4'd0, "R3 hold chain_en low");
      // Carry gating at nine (R5)
      tick(1, 0, 1, 1, 4'd9, "R2 load nine");
      tick(1, 1, 0, 1, 4'd0, "R5 carry with cnt_en low");
      check("R5 carry high at nine", carry_out, 1);
      tick(1, 1, 1, 0, 4'd0, "R5 carry with chain_en low");
      check("R5 carry gated", carry_out, 0);
      tick(1, 1, 1, 1, 4'd0, "R4 wrap nine to zero");
      check("R4 wrapped", digit, 0);
      // Non-decimal codes (R6)
      for (int c = 10; c < 16; c++) begin
         tick(1, 0, 1, 1, 4'(c), "R6 load code");
         tick(1, 1, 1, 1, 4'd0, "R6 step one");
         tick(1, 1, 1, 1, 4'd0, "R6 step two");
         check("R6 back in range", (digit <= 9) ? 1 : 0, 1);
      end
      // Clear between edges, then clear held with load active (R1, R8)
      tick(1, 0, 1, 1, 4'd5, "R2 load five");
      @(posedge clk);
      model = ref_step(model);
      #3 arst_n = 1'b0;
      #1 check("R1 clear without edge", digit, 0);
      model = 0;
      @(negedge clk);
      tick(0, 0, 1, 1, 4'd8, "R8 clear over load");
      tick(1, 1, 0, 0, 4'd0, "R1 release");
      // Random mix against model (R2, R3, R4, R8)
      for (int i = 0; i < 3000; i++) begin
         logic r, l;
         r = ($urandom_range(0, 39) != 0);
         l = ($urandom_range(0, 7) != 0);
         tick(r, l, 1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 3) != 0),
              4'($urandom_range(0, 15)), "R3 random");
      end
      // Two-stage chain (R7)
      @(negedge clk);
      cas_rst_n = 1'b1; cas_run = 1'b1;
      for (int k = 1; k <= 120; k++) begin
         @(negedge clk);
         check("R7 chain value", hi_d * 10 + lo_d, k % 100);
      end
      cas_run = 1'b0;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule